// File: doc/BRIEF.md
# Bank Auto-Precharge Timing Tracker

This block follows a single memory bank through its open, auto-precharge and recovery phases. Each cycle it reads the decoded command aimed at that bank: idle, open the row, read with auto-precharge, or write with auto-precharge. It then works out the cycle in which the bank starts closing by itself, and the first cycle in which the bank may be opened again. The fixed burst is four beats. The read latency is 2 or 3 cycles and is chosen by one input that is sampled with the read command.

The tracker raises a one-cycle pulse when the internal close begins. A ready flag shows that the next legal command for the bank would be accepted without penalty. A level shows whether a row is open, and a violation flag marks any command that is illegal or early in the cycle in which it is presented. A flagged command leaves the tracked state unchanged. A command scheduler upstream would gate its choices with the ready flag and use the violation flag as a protocol monitor.

The three interval lengths are elaboration-time parameters, each at least one cycle: the minimum open time before the close (`T_RAS`), the read close-to-reopen recovery (`T_APR`), and the write last-data-to-reopen interval (`T_DAL`).

Top module: `apt_bank_tracker`

## Requirements
- R1: After synchronous reset, in the first cycle with an idle command: `ready`=1, `bank_open`=0, `pre_start`=0 and `violation`=0.
- R2: Commands use `cmd` 2'b00 idle, 2'b01 open (ACT), 2'b10 read with auto-precharge, 2'b11 write with auto-precharge. When `ready` is high and no row is open, an ACT is accepted and `bank_open` is 1 from the next cycle.
- R3: For a read accepted in cycle r, the last data beat falls in cycle r+L+3, where L is 3 when `cas_lat3`=1 and 2 otherwise. The close point lies 2 cycles before that beat for L=3 and 1 cycle before it for L=2. The close point is therefore cycle r+4 for both latencies, and `pre_start` is high for exactly one cycle.
- R4: `pre_start` never occurs earlier than cycle a+T_RAS, where a is the accepted ACT. When the data-derived point comes first, the pulse is delayed to a+T_RAS.
- R5: After a read whose pulse falls in cycle p, `ready` is 0 from the cycle after the read through cycle p+T_APR-1, and it is 1 in cycle p+T_APR.
- R6: For a write accepted in cycle w, the last data beat is w+3 and the pulse falls in max(w+4, a+T_RAS). `ready` returns in cycle max(w+3+T_DAL, p+1) and is 0 before that, from cycle w+1 on.
- R7: While a read or write auto-precharge is pending or recovering, another read or write command is flagged. Only ACT may follow.
- R8: An ACT presented before `ready` returns is flagged. An ACT presented in the first cycle of the returned `ready` is accepted.
- R9: A read or write command while no row is open is flagged and ignored: `bank_open` stays 0 and no `pre_start` follows.
- R10: An ACT while a row is open is flagged and ignored. The row stays open and the T_RAS window still counts from the first ACT.
- R11: `violation` is combinational in the offending command's cycle and lasts only that cycle. An idle command is never flagged, and a flagged command does not change the state.
- R12: While a row is open and no auto-precharge is pending, `ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cmd | input | 2 | Decoded command for this bank in the current cycle |
| cas_lat3 | input | 1 | Read latency select: 1 = three cycles, 0 = two cycles |
| pre_start | output | 1 | One-cycle pulse in the cycle the internal close begins |
| ready | output | 1 | Next legal command would be accepted this cycle |
| bank_open | output | 1 | A row is open (including while a close is pending) |
| violation | output | 1 | Current command is illegal or early |

## Verification
If the state register or one of the interval counters went wrong, the effect would appear at the ports within one close cycle. `pre_start` would land one or more cycles off its predicted slot, or would fire twice or not at all. `ready` would return early or late against max-of-intervals arithmetic that the bench computes on its own. A corrupted legality decision shows up in the same cycle as a wrong `violation`. A flagged command that leaks into the state shows up in the next cycle, as a changed `bank_open` or a shifted close point. The directed cases are arranged so that each of the three intervals in turn dominates the result, which makes a swapped or miscounted counter visible.

// File: rtl/apt_pkg.sv
package apt_pkg;

    localparam int BURST_LEN = 4;

    localparam int CTR_RAS = 0;
    localparam int CTR_PRE = 1;
    localparam int CTR_REC = 2;
    localparam int CTR_DAL = 3;
    localparam int NUM_CTR = 4;

    typedef enum logic [1:0] {
        CMD_NOP   = 2'b00,
        CMD_ACT   = 2'b01,
        CMD_READA = 2'b10,
        CMD_WRITA = 2'b11
    } apt_cmd_e;

    typedef enum logic [2:0] {
        ST_CLOSED  = 3'd0,
        ST_OPEN    = 3'd1,
        ST_RD_WAIT = 3'd2,
        ST_WR_WAIT = 3'd3,
        ST_RECOVER = 3'd4
    } apt_state_e;

    typedef struct packed {
        logic accept;
        logic flag;
        logic ready;
    } apt_verdict_t;

    // Cycles from a read command to the cycle the close starts
    function automatic int read_start_offset(input logic cl3);
        int lat;
        int lead;
        lat  = cl3 ? 3 : 2;
        lead = cl3 ? 2 : 1;
        return lat + BURST_LEN - 1 - lead;
    endfunction

    // Cycles from a write command to the cycle after its last data beat
    function automatic int write_start_offset();
        return BURST_LEN;
    endfunction

    // Counter preload that reaches zero in cycle (cmd + last beat + dal)
    function automatic int write_dal_preload(input int dal);
        return BURST_LEN - 2 + dal;
    endfunction

endpackage

// File: rtl/apt_down_counter.sv
module apt_down_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/apt_cmd_check.sv
module apt_cmd_check
    import apt_pkg::*;
(
    input  apt_state_e   state,
    input  apt_cmd_e     cmd,
    input  logic         rec_zero,
    input  logic         dal_zero,
    output apt_verdict_t verdict
);
    logic act_ok;
    logic rw_ok;

    always_comb begin
        act_ok = (state == ST_CLOSED) ||
                 ((state == ST_RECOVER) && rec_zero && dal_zero);
        rw_ok  = (state == ST_OPEN);

        verdict.ready = act_ok || rw_ok;
        unique case (cmd)
            CMD_NOP:   verdict.accept = 1'b0;
            CMD_ACT:   verdict.accept = act_ok;
            CMD_READA: verdict.accept = rw_ok;
            CMD_WRITA: verdict.accept = rw_ok;
            default:   verdict.accept = 1'b0;
        endcase
        verdict.flag = (cmd != CMD_NOP) && !verdict.accept;
    end
endmodule

// File: rtl/apt_bank_fsm.sv
module apt_bank_fsm
    import apt_pkg::*;
#(
    parameter int T_RAS = 5,
    parameter int T_APR = 2,
    parameter int T_DAL = 4,
    parameter int CNT_W = 8
) (
    input  logic                            clk,
    input  logic                            rst,
    input  apt_cmd_e                        cmd,
    input  logic                            accept,
    input  logic                            cl3,
    input  logic [NUM_CTR-1:0]              ctr_zero,
    output apt_state_e                      state,
    output logic                            pre_start,
    output logic [NUM_CTR-1:0]              ctr_ld,
    output logic [NUM_CTR-1:0][CNT_W-1:0]   ctr_val
);
    localparam logic [CNT_W-1:0] RAS_LD  = CNT_W'(T_RAS - 1);
    localparam logic [CNT_W-1:0] APR_LD  = CNT_W'(T_APR - 1);
    localparam logic [CNT_W-1:0] DAL_LD  = CNT_W'(write_dal_preload(T_DAL));
    localparam logic [CNT_W-1:0] WPRE_LD = CNT_W'(write_start_offset() - 1);

    apt_state_e state_q;
    apt_state_e state_d;
    logic       waiting;
    logic       rec_done;

    assign state    = state_q;
    assign waiting  = (state_q == ST_RD_WAIT) || (state_q == ST_WR_WAIT);
    assign rec_done = ctr_zero[CTR_REC] && ctr_zero[CTR_DAL];
    assign pre_start = waiting && ctr_zero[CTR_PRE] && ctr_zero[CTR_RAS];

    always_comb begin
        state_d = state_q;
        ctr_ld  = '0;
        ctr_val = '0;

        unique case (state_q)
            ST_CLOSED: begin
                if (accept && cmd == CMD_ACT) begin
                    state_d          = ST_OPEN;
                    ctr_ld[CTR_RAS]  = 1'b1;
                    ctr_val[CTR_RAS] = RAS_LD;
                end
            end
            ST_OPEN: begin
                if (accept && cmd == CMD_READA) begin
                    state_d          = ST_RD_WAIT;
                    ctr_ld[CTR_PRE]  = 1'b1;
                    ctr_val[CTR_PRE] = CNT_W'(read_start_offset(cl3) - 1);
                    ctr_ld[CTR_DAL]  = 1'b1;
                    ctr_val[CTR_DAL] = '0;
                end else if (accept && cmd == CMD_WRITA) begin
                    state_d          = ST_WR_WAIT;
                    ctr_ld[CTR_PRE]  = 1'b1;
                    ctr_val[CTR_PRE] = WPRE_LD;
                    ctr_ld[CTR_DAL]  = 1'b1;
                    ctr_val[CTR_DAL] = DAL_LD;
                end
            end
            ST_RD_WAIT, ST_WR_WAIT: begin
                if (pre_start) begin
                    state_d          = ST_RECOVER;
                    ctr_ld[CTR_REC]  = 1'b1;
                    ctr_val[CTR_REC] = (state_q == ST_RD_WAIT) ? APR_LD : '0;
                end
            end
            ST_RECOVER: begin
                if (accept && cmd == CMD_ACT) begin
                    state_d          = ST_OPEN;
                    ctr_ld[CTR_RAS]  = 1'b1;
                    ctr_val[CTR_RAS] = RAS_LD;
                end else if (rec_done) begin
                    state_d = ST_CLOSED;
                end
            end
            default: state_d = ST_CLOSED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_CLOSED;
        end else begin
            state_q <= state_d;
        end
    end
endmodule

// File: rtl/apt_bank_tracker.sv
module apt_bank_tracker
    import apt_pkg::*;
#(
    parameter int T_RAS = 5,
    parameter int T_APR = 2,
    parameter int T_DAL = 4,
    parameter int CNT_W = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] cmd,
    input  logic       cas_lat3,
    output logic       pre_start,
    output logic       ready,
    output logic       bank_open,
    output logic       violation
);
    apt_cmd_e                        cmd_e;
    apt_state_e                      state;
    apt_verdict_t                    verdict;
    logic [NUM_CTR-1:0]              ctr_zero;
    logic [NUM_CTR-1:0]              ctr_ld;
    logic [NUM_CTR-1:0][CNT_W-1:0]   ctr_val;

    assign cmd_e = apt_cmd_e'(cmd);

    apt_cmd_check u_check (
        .state    (state),
        .cmd      (cmd_e),
        .rec_zero (ctr_zero[CTR_REC]),
        .dal_zero (ctr_zero[CTR_DAL]),
        .verdict  (verdict)
    );

    apt_bank_fsm #(
        .T_RAS (T_RAS),
        .T_APR (T_APR),
        .T_DAL (T_DAL),
        .CNT_W (CNT_W)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd_e),
        .accept    (verdict.accept),
        .cl3       (cas_lat3),
        .ctr_zero  (ctr_zero),
        .state     (state),
        .pre_start (pre_start),
        .ctr_ld    (ctr_ld),
        .ctr_val   (ctr_val)
    );

    for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
        apt_down_counter #(.CNT_W(CNT_W)) u_ctr (
            .clk      (clk),
            .rst      (rst),
            .load     (ctr_ld[g]),
            .load_val (ctr_val[g]),
            .zero     (ctr_zero[g])
        );
    end

    assign ready     = verdict.ready;
    assign violation = verdict.flag;
    assign bank_open = (state == ST_OPEN) || (state == ST_RD_WAIT) ||
                       (state == ST_WR_WAIT);
endmodule

// File: rtl/apt_bank_checker.sv
module apt_bank_checker
    import apt_pkg::*;
#(
    parameter int T_RAS = 5
) (
    input logic       clk,
    input logic       rst,
    input logic [1:0] cmd,
    input logic       pre_start,
    input logic       ready,
    input logic       bank_open,
    input logic       violation
);
    logic [15:0] since_act;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_act <= 16'hFFFF;
        end else if (cmd == CMD_ACT && !violation) begin
            since_act <= 16'd1;
        end else if (since_act != 16'hFFFF) begin
            since_act <= since_act + 16'd1;
        end
    end

    assert_ras_window_R4: assert property (@(posedge clk) disable iff (rst)
        pre_start |-> (32'(since_act) >= T_RAS));

    assert_single_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        pre_start |=> !pre_start);

    assert_busy_at_close_R5: assert property (@(posedge clk) disable iff (rst)
        pre_start |-> !ready);

    assert_nop_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_NOP) |-> !violation);

    assert_flag_keeps_state_R11: assert property (@(posedge clk) disable iff (rst)
        (violation && !pre_start) |=> $stable(bank_open));

    assert_open_by_act_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(bank_open) |-> ($past(cmd) == CMD_ACT));

    assert_closed_rw_R9: assert property (@(posedge clk) disable iff (rst)
        (!bank_open && (cmd == CMD_READA || cmd == CMD_WRITA)) |-> violation);
endmodule

bind apt_bank_tracker apt_bank_checker #(.T_RAS(T_RAS)) u_apt_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd       (cmd),
    .pre_start (pre_start),
    .ready     (ready),
    .bank_open (bank_open),
    .violation (violation)
);

// File: tb/test_apt_bank_tracker.sv
`timescale 1ns/1ps
module test_apt_bank_tracker;
    localparam int TRAS = 6;
    localparam int TAPR = 3;
    localparam int TDAL = 5;
    localparam logic [1:0] C_NOP = 2'b00, C_ACT = 2'b01, C_RDA = 2'b10, C_WRA = 2'b11;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] cmd = C_NOP;
    logic cas_lat3 = 1'b1;
    logic pre_start, ready, bank_open, violation;
    int n_tests = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    apt_bank_tracker #(.T_RAS(TRAS), .T_APR(TAPR), .T_DAL(TDAL), .CNT_W(8)) i_apt_bank_tracker (
        .clk(clk), .rst(rst), .cmd(cmd), .cas_lat3(cas_lat3),
        .pre_start(pre_start), .ready(ready), .bank_open(bank_open), .violation(violation)
    );

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick(input logic [1:0] c);
        @(negedge clk);
        cmd = c;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        cmd = C_NOP;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // R1: reset state
    task automatic t_reset();
        do_reset();
        tick(C_NOP);
        check("R1", "ready", int'(ready), 1);
        check("R1", "bank_open", int'(bank_open), 0);
        check("R1", "pre_start", int'(pre_start), 0);
        check("R1", "violation", int'(violation), 0);
    endtask

    // R3/R4/R5: read with auto-precharge, command issued 'gap' cycles after ACT
    task automatic t_read(input int gap, input logic c3, input string req_p);
        int exp_p, exp_r, first_p, first_r, npulse;
        do_reset();
        cas_lat3 = c3;
        tick(C_ACT);
        check("R2", "ACT accepted", int'(violation), 0);
        for (int i = 1; i < gap; i++) tick(C_NOP);
        tick(C_RDA);
        check("R12", "ready while open", int'(ready), 1);
        check("R12", "read accepted", int'(violation), 0);
        exp_p = imax(gap + 4, TRAS);
        exp_r = exp_p + TAPR;
        first_p = -1; first_r = -1; npulse = 0;
        for (int cyc = gap + 1; cyc <= gap + 25; cyc++) begin
            tick(C_NOP);
            if (pre_start) begin
                npulse++;
                if (first_p < 0) first_p = cyc;
            end
            if (ready && first_r < 0) first_r = cyc;
        end
        check(req_p, "read close cycle", first_p, exp_p);
        check("R3", "close pulse count", npulse, 1);
        check("R5", "read ready cycle", first_r, exp_r);
        tick(C_ACT);
        check("R2", "reopen accepted", int'(violation), 0);
        tick(C_NOP);
        check("R2", "bank_open after ACT", int'(bank_open), 1);
    endtask

    // R6: write with auto-precharge
    task automatic t_write(input int gap);
        int exp_p, exp_r, first_p, first_r, npulse;
        do_reset();
        tick(C_ACT);
        for (int i = 1; i < gap; i++) tick(C_NOP);
        tick(C_WRA);
        check("R6", "write accepted", int'(violation), 0);
        exp_p = imax(gap + 4, TRAS);
        exp_r = imax(gap + 3 + TDAL, exp_p + 1);
        first_p = -1; first_r = -1; npulse = 0;
        for (int cyc = gap + 1; cyc <= gap + 25; cyc++) begin
            tick(C_NOP);
            if (pre_start) begin
                npulse++;
                if (first_p < 0) first_p = cyc;
            end
            if (ready && first_r < 0) first_r = cyc;
        end
        check("R6", "write close cycle", first_p, exp_p);
        check("R6", "write close pulse count", npulse, 1);
        check("R6", "write ready cycle", first_r, exp_r);
    endtask

    // R7/R8/R11: illegal commands during a read close, ACT at the ready boundary
    task automatic t_read_boundary();
        do_reset();
        cas_lat3 = 1'b1;
        tick(C_ACT);                          // cycle 0
        tick(C_RDA);                          // cycle 1, close at 6, ready at 9
        tick(C_NOP); tick(C_NOP); tick(C_NOP); // cycles 2..4
        tick(C_RDA);                          // cycle 5
        check("R7", "read during pending flagged", int'(violation), 1);
        tick(C_NOP);                          // cycle 6
        check("R11", "flag lasts one cycle", int'(violation), 0);
        check("R11", "close unaffected by flagged read", int'(pre_start), 1);
        tick(C_ACT);                          // cycle 7
        check("R8", "early ACT flagged", int'(violation), 1);
        tick(C_WRA);                          // cycle 8
        check("R7", "write during recovery flagged", int'(violation), 1);
        tick(C_ACT);                          // cycle 9
        check("R8", "ACT at ready boundary", int'(violation), 0);
        check("R8", "ready at boundary", int'(ready), 1);
        tick(C_NOP);
        check("R8", "bank_open after boundary ACT", int'(bank_open), 1);
    endtask

    // R8: write recovery boundary
    task automatic t_write_boundary();
        do_reset();
        tick(C_ACT);                          // cycle 0
        tick(C_WRA);                          // cycle 1, ready at 9
        for (int i = 2; i <= 7; i++) tick(C_NOP);
        tick(C_ACT);                          // cycle 8
        check("R8", "early ACT after write flagged", int'(violation), 1);
        tick(C_ACT);                          // cycle 9
        check("R8", "ACT at write ready boundary", int'(violation), 0);
    endtask

    // R9: read/write while closed
    task automatic t_closed_rw();
        int npulse;
        do_reset();
        tick(C_RDA);
        check("R9", "read while closed flagged", int'(violation), 1);
        tick(C_NOP);
        check("R9", "bank stays closed", int'(bank_open), 0);
        check("R9", "ready stays", int'(ready), 1);
        tick(C_WRA);
        check("R9", "write while closed flagged", int'(violation), 1);
        npulse = 0;
        for (int i = 0; i < 10; i++) begin
            tick(C_NOP);
            if (pre_start) npulse++;
        end
        check("R9", "no close after ignored commands", npulse, 0);
        tick(C_ACT);
        check("R9", "ACT still accepted", int'(violation), 0);
    endtask

    // R10: ACT while open leaves state and T_RAS window alone
    task automatic t_open_act();
        int first_p;
        do_reset();
        cas_lat3 = 1'b0;
        tick(C_ACT);                          // cycle 0
        tick(C_NOP);                          // cycle 1
        tick(C_ACT);                          // cycle 2
        check("R10", "ACT while open flagged", int'(violation), 1);
        tick(C_RDA);                          // cycle 3, close at max(7,6)=7
        check("R10", "read after flagged ACT accepted", int'(violation), 0);
        check("R10", "row still open", int'(bank_open), 1);
        first_p = -1;
        for (int cyc = 4; cyc <= 20; cyc++) begin
            tick(C_NOP);
            if (pre_start && first_p < 0) first_p = cyc;
        end
        check("R10", "T_RAS from first ACT", first_p, 7);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_read(1, 1'b1, "R4");
        t_read(4, 1'b1, "R3");
        t_read(4, 1'b0, "R3");
        t_read(2, 1'b0, "R4");
        t_write(1);
        t_write(5);
        t_read_boundary();
        t_write_boundary();
        t_closed_rw();
        t_open_act();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule